// File: doc/BRIEF.md
# Precise-Exception Pipeline Controller

This block is the exception path of a five-stage in-order pipeline: fetch, decode, execute, memory and write-back. Four pipeline registers sit between the stages. Each register carries a valid bit, a trap marker, the instruction's PC and a 3-bit fault code. The datapath is reduced to the PC of each instruction. Faults are injected through one input per stage, and each such input applies to the instruction that occupies that stage in the current cycle.

A stage that detects a fault writes the code into the next pipeline register and then waits. While it waits it discards whatever arrives from upstream. Stages further down that receive a coded instruction also enter the wait state and pass the code on. The fault takes effect only when it reaches write-back, so the oldest faulting instruction always wins. At that point a recovery command flushes the pipeline, and fetch injects a trap carrying the code. When the trap reaches the memory stage, that stage reads an 8-entry vector table. When the trap reaches write-back, the value read becomes the new PC, and fetch resumes on the next cycle.

Top module: `exc_pipe_ctrl`

## Requirements
- R1: After reset, `pc` is 0 and `retire`, `trap_start` and `redirect` are all low.
- R2: When no fault is pending, one instruction is fetched per cycle at `pc`, and `pc` then advances by 4. Each fetched instruction shows `retire` with its PC on `retire_pc` in the fourth cycle after the edge that fetched it, and instructions retire in fetch order.
- R3: The fault codes are 1 for fetch (`flt_if`), 2 for decode (`flt_id`), 3 for execute (`flt_ex`) and 4 for memory (`flt_mem`); 0 means no fault. When a faulting instruction reaches write-back, `trap_start` is high for one cycle and `trap_code` shows its code.
- R4: If several instructions fault, only the oldest one raises `trap_start`, even when a younger one detected its fault earlier or in the same cycle.
- R5: Older instructions ahead of a faulting instruction retire normally. The faulting instruction and all younger ones never assert `retire`.
- R6: After a fetch fault, `pc` holds its value until recovery.
- R7: `redirect` goes high exactly 4 cycles after `trap_start`. From the next cycle on, `pc` holds the vector and fetch resumes from it.
- R8: No `retire` occurs from the cycle after `trap_start` up to and including the `redirect` cycle.
- R9: The vector table has 8 entries of 32 bits, written through `vt_we`/`vt_idx`/`vt_data`. The entry read for recovery is the one whose index equals the fault code.
- R10: Fault inputs have no effect on empty pipeline slots, on the trap, or while recovery is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_if | input | 1 | Fetch fault on the instruction being fetched |
| flt_id | input | 1 | Decode fault on the instruction in decode |
| flt_ex | input | 1 | Divide-by-zero fault on the instruction in execute |
| flt_mem | input | 1 | Data page fault on the instruction in the memory stage |
| vt_we | input | 1 | Vector table write enable |
| vt_idx | input | 3 | Vector table write index |
| vt_data | input | 32 | Vector table write data |
| pc | output | 32 | Fetch PC |
| retire | output | 1 | An instruction commits in write-back this cycle |
| retire_pc | output | 32 | PC of the committing instruction, or of the faulting instruction during `trap_start` |
| trap_start | output | 1 | Recovery command: a faulting instruction reached write-back |
| trap_code | output | 3 | Code of that faulting instruction |
| redirect | output | 1 | The trap is in write-back and the PC is being loaded |

## Verification
On every cycle, the assertions check these invariants:
- The PC stays frozen during a fetch stall and during recovery.
- Retire, trap start and redirect never overlap.
- A recovery command is never repeated on consecutive cycles.
- Its code is in the range 1 to 4.
- Recovery ends with the cycle after a redirect.

Whether the right instruction wins, whether younger instructions are dropped, and whether the PC lands on the vector for that code can only be shown by the bench. It runs an instruction-level model under staggered and simultaneous faults in different stages, with fault pulses sent during recovery.

// File: rtl/exc_pipe_ctrl.sv
module exc_pipe_ctrl #(
  parameter int XLEN = 32,
  parameter int CW   = 3,
  parameter int VTD  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flt_if,
  input  logic            flt_id,
  input  logic            flt_ex,
  input  logic            flt_mem,
  input  logic            vt_we,
  input  logic [CW-1:0]   vt_idx,
  input  logic [XLEN-1:0] vt_data,
  output logic [XLEN-1:0] pc,
  output logic            retire,
  output logic [XLEN-1:0] retire_pc,
  output logic            trap_start,
  output logic [CW-1:0]   trap_code,
  output logic            redirect
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic            s_v [1:4];
  logic            s_t [1:4];
  logic [CW-1:0]   s_c [1:4];
  logic [XLEN-1:0] s_pc [1:4];
  logic [XLEN-1:0] vt [VTD];
  logic [3:0]      hold;
  logic            rec;
  logic [3:1]      flt;

  assign flt        = {flt_mem, flt_ex, flt_id};
  assign retire     = s_v[4] && !s_t[4] && s_c[4] == '0;
  assign trap_start = s_v[4] && !s_t[4] && s_c[4] != '0;
  assign redirect   = s_v[4] && s_t[4];
  assign retire_pc  = s_pc[4];
  assign trap_code  = s_c[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc   <= '0;
      rec  <= 1'b0;
      hold <= '0;
      for (int k = 1; k <= 4; k++) begin
        s_v[k]  <= 1'b0;
        s_t[k]  <= 1'b0;
        s_c[k]  <= '0;
        s_pc[k] <= '0;
      end
      for (int i = 0; i < VTD; i++) vt[i] <= '0;
    end else begin
      if (vt_we) vt[vt_idx] <= vt_data;
      if (trap_start) begin
        rec  <= 1'b1;
        hold <= '0;
        for (int k = 2; k <= 4; k++) begin
          s_v[k] <= 1'b0;
          s_t[k] <= 1'b0;
          s_c[k] <= '0;
        end
        s_v[1]  <= 1'b1;
        s_t[1]  <= 1'b1;
        s_c[1]  <= s_c[4];
        s_pc[1] <= pc;
      end else begin
        if (redirect) begin
          pc  <= s_pc[4];
          rec <= 1'b0;
        end
        if (!rec && !hold[0]) begin
          s_v[1]  <= 1'b1;
          s_t[1]  <= 1'b0;
          s_pc[1] <= pc;
          s_c[1]  <= flt_if ? CW'(1) : '0;
          pc      <= pc + STEP;
          if (flt_if) hold[0] <= 1'b1;
        end else begin
          s_v[1] <= 1'b0;
          s_t[1] <= 1'b0;
          s_c[1] <= '0;
        end
        for (int k = 1; k <= 3; k++) begin
          if (hold[k] || !s_v[k]) begin
            s_v[k+1] <= 1'b0;
            s_t[k+1] <= 1'b0;
            s_c[k+1] <= '0;
          end else begin
            s_v[k+1]  <= 1'b1;
            s_t[k+1]  <= s_t[k];
            s_pc[k+1] <= (k == 3 && s_t[k]) ? vt[s_c[k]] : s_pc[k];
            if (!s_t[k] && s_c[k] != '0) begin
              s_c[k+1] <= s_c[k];
              hold[k]  <= 1'b1;
            end else if (!s_t[k] && flt[k]) begin
              s_c[k+1] <= CW'(k + 1);
              hold[k]  <= 1'b1;
            end else begin
              s_c[k+1] <= s_c[k];
            end
          end
        end
      end
    end
  end

  p_no_retire_in_recovery_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rec |-> !retire);
  p_single_command_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_start |=> !trap_start);
  p_code_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_start |-> (trap_code >= CW'(1) && trap_code <= CW'(4)));
  p_pc_frozen_recovery_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rec && !redirect |=> $stable(pc));
  p_pc_frozen_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold[0] |=> $stable(pc));
  p_resume_after_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !rec);
  p_exclusive_events_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({retire, trap_start, redirect}));
endmodule

// File: tb/exc_pipe_ctrl_test.sv
module exc_pipe_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic flt_if = 0, flt_id = 0, flt_ex = 0, flt_mem = 0;
  logic vt_we = 0;
  logic [2:0] vt_idx = '0;
  logic [31:0] vt_data = '0;
  logic [31:0] pc, retire_pc;
  logic retire, trap_start, redirect;
  logic [2:0] trap_code;

  exc_pipe_ctrl uut (.clk(clk), .rst_n(rst_n), .flt_if(flt_if), .flt_id(flt_id),
    .flt_ex(flt_ex), .flt_mem(flt_mem), .vt_we(vt_we), .vt_idx(vt_idx),
    .vt_data(vt_data), .pc(pc), .retire(retire), .retire_pc(retire_pc),
    .trap_start(trap_start), .trap_code(trap_code), .redirect(redirect));

  always #4 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] vecval(input int i);
    return 32'h0000_1000 * i + 32'h40;
  endfunction

  typedef struct { logic [31:0] pc; int code; int age; } ent_t;
  ent_t q[$];
  logic [31:0] mpc = '0;
  logic [31:0] mvt [8];
  bit mrec = 0, mhold = 0;
  int recage = 0, tcode = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); mpc = '0; mrec = 0; mhold = 0; recage = 0; tcode = 0;
      foreach (mvt[i]) mvt[i] = '0;
    end else begin
      bit at_wb, e_trap, e_red, ofetch;
      int first;
      at_wb  = q.size() > 0 && q[0].age == 4;
      e_trap = at_wb && q[0].code != 0;
      e_red  = recage == 4;
      ofetch = !mrec && !mhold;
      if (vt_we) mvt[vt_idx] = vt_data;
      if (e_trap) begin
        tcode = q[0].code; q.delete(); mrec = 1; recage = 1; mhold = 0;
      end else begin
        if (e_red) begin mpc = mvt[tcode]; mrec = 0; recage = 0; end
        else if (recage > 0) recage++;
        foreach (q[i]) begin
          if (q[i].code == 0) begin
            if (q[i].age == 1 && flt_id) q[i].code = 2;
            if (q[i].age == 2 && flt_ex) q[i].code = 3;
            if (q[i].age == 3 && flt_mem) q[i].code = 4;
          end
        end
        first = -1;
        foreach (q[i]) if (first < 0 && q[i].code != 0) first = i;
        if (first >= 0) while (q.size() > first + 1) void'(q.pop_back());
        foreach (q[i]) q[i].age++;
        if (q.size() > 0 && q[0].age > 4) void'(q.pop_front());
        if (ofetch) begin
          ent_t e;
          e.pc = mpc; e.code = flt_if ? 1 : 0; e.age = 1;
          q.push_back(e);
          if (flt_if) mhold = 1;
          mpc = mpc + 4;
        end
      end
    end
  end

  int ntrap = 0, last_code = 0, gap = 0, red_gap = 0, ret_in_rec = 0;
  bit ingap = 0, grab = 0;
  logic [31:0] vec_seen = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit ew, er, et;
      ew = q.size() > 0 && q[0].age == 4;
      er = ew && q[0].code == 0;
      et = ew && q[0].code != 0;
      chk(pc == mpc, "R2 pc", pc, mpc);
      chk(retire == er, "R5 retire", retire, er);
      if (er) chk(retire_pc == q[0].pc, "R2 retire_pc", retire_pc, q[0].pc);
      chk(trap_start == et, "R3 trap_start", trap_start, et);
      if (et) chk(trap_code == 3'(q[0].code), "R4 trap_code", trap_code, q[0].code);
      chk(redirect == (recage == 4), "R7 redirect", redirect, recage == 4);
      if (retire && mrec) ret_in_rec++;
      if (grab) begin vec_seen = pc; grab = 0; end
      if (trap_start) begin ntrap++; last_code = trap_code; gap = 0; ingap = 1; end
      else if (ingap) gap++;
      if (redirect) begin red_gap = gap; ingap = 0; grab = 1; end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: flt_if = 1;
      1: flt_id = 1;
      2: flt_ex = 1;
      default: flt_mem = 1;
    endcase
    @(negedge clk);
    flt_if = 0; flt_id = 0; flt_ex = 0; flt_mem = 0;
  endtask

  initial begin
    int t0;
    logic [31:0] hold_pc;
    run(2);
    rst_n = 1;
    #1;
    chk(pc == 0 && !retire && !trap_start && !redirect, "R1 reset state", pc, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); vt_we = 1; vt_idx = 3'(i); vt_data = vecval(i);
    end
    @(negedge clk); vt_we = 0;
    run(6);
    // R3 / R9: execute fault (code 3)
    t0 = ntrap;
    pulse(2); run(12);
    chk(last_code == 3, "R3 ex code", last_code, 3);
    chk(ntrap == t0 + 1, "R3 one trap", ntrap, t0 + 1);
    chk(red_gap == 4, "R7 trap-to-redirect", red_gap, 4);
    chk(vec_seen == vecval(3), "R9 vector for code 3", vec_seen, vecval(3));
    // R6: fetch fault stalls pc
    pulse(0);
    hold_pc = pc; run(2);
    chk(pc == hold_pc, "R6 pc held", pc, hold_pc);
    run(10);
    chk(last_code == 1, "R3 if code", last_code, 1);
    chk(vec_seen == vecval(1), "R9 vector for code 1", vec_seen, vecval(1));
    // decode fault
    pulse(1); run(12);
    chk(last_code == 2, "R3 id code", last_code, 2);
    // memory fault
    pulse(3); run(12);
    chk(last_code == 4, "R3 mem code", last_code, 4);
    chk(vec_seen == vecval(4), "R9 vector for code 4", vec_seen, vecval(4));
    // R4: younger detects first, older faults one cycle later in MEM
    t0 = ntrap;
    @(negedge clk); flt_id = 1;
    @(negedge clk); flt_id = 0; flt_mem = 1;
    @(negedge clk); flt_mem = 0;
    run(12);
    chk(last_code == 4, "R4 older wins", last_code, 4);
    chk(ntrap == t0 + 1, "R4 single trap", ntrap, t0 + 1);
    // R4: same-cycle decode and execute faults
    @(negedge clk); flt_id = 1; flt_ex = 1;
    @(negedge clk); flt_id = 0; flt_ex = 0;
    run(12);
    chk(last_code == 3, "R4 same-cycle older wins", last_code, 3);
    // R10: fault pulses during recovery are ignored
    t0 = ntrap;
    pulse(2);
    while (!trap_start) @(negedge clk);
    @(negedge clk); flt_if = 1; flt_id = 1; flt_ex = 1; flt_mem = 1;
    run(3);
    flt_if = 0; flt_id = 0; flt_ex = 0; flt_mem = 0;
    run(12);
    chk(ntrap == t0 + 1, "R10 faults in recovery ignored", ntrap, t0 + 1);
    chk(vec_seen == vecval(3), "R10 vector unchanged", vec_seen, vecval(3));
    chk(ret_in_rec == 0, "R8 no retire in recovery", ret_in_rec, 0);
    run(10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++; checks++;
      $display("FAIL watchdog R2: actual=%0d expected=%0d", cycles, 5000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule